// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Read Acknowledge

This block gathers up to 32 interrupt request lines into two processor interrupt outputs. One is a normal request and the other is a fast request. Each line has its own configuration word. The word sets the line's priority level, whether the line is edge or level sensitive, and which of the two outputs it is steered to. The block latches pending requests and filters them through a mask register. It then picks one winner per output and stores the winner's line number in a vector register.

Software reads the vector register to learn which line fired. For an edge-type line, that read also acknowledges the request. Each output raises once and then holds. It stays quiet for new arrivals until software writes the matching bit of the control register, which lowers and re-arms the output.

The register port is a request channel with valid/ready. `bus_ready` is tied high, so every request is accepted on the cycle that `bus_valid` is high. The requester must hold its request fields stable while `bus_valid` is high. A read returns its data on `rd_data` with `rd_valid` high exactly one cycle after acceptance. The response channel has no back-pressure: the requester must take the data on that cycle.

Top module: `pintc`

## Requirements
- R1: After reset, the pending register reads 0, every implemented mask bit reads 1, every configuration word reads 0 (edge, normal output, priority 0), both vectors read 0, both outputs are low, and both outputs are armed.
- R2: The mask register sits at byte offset 0x04, with bit n for line n; a 1 blocks that line from both outputs. It reads back the written value limited to the implemented lines. A newly unmasked pending line can raise an armed output from the cycle after the write.
- R3: An edge-type line becomes pending on the first clock at which its input is sampled high after being sampled low. Holding the input high does not re-raise the line after software clears it.
- R4: A level-type line becomes pending on every clock at which its input is high. When its input falls, its pending bit is cleared.
- R5: The pending register is at offset 0x00. A write ANDs the written value into it, except that bits of level-type lines whose input is currently high stay set.
- R6: Among the unmasked pending lines steered to an output, the winner is the line with the numerically smallest priority. On a tie, the highest line number wins. Configuration bit 0 = 1 steers the line to the fast output, and 0 steers it to the normal output.
- R7: An armed output with at least one eligible line rises on the next clock, latches the winner into its vector and disarms. It then stays high, with its vector unchanged, until a write to control offset 0x18 with bit 0 (normal) or bit 1 (fast) set. That write lowers and re-arms the output on that clock, and the output is evaluated again on the following clock.
- R8: A read of offset 0x10 (normal vector) or 0x14 (fast vector) returns the latched line number. If that line is edge type, the read also clears its pending bit. A level-type line is left pending.
- R9: A write to offset 0x9C makes only the lowest-numbered set bit of the written data pending. That register reads as 0.
- R10: The configuration word of line n is at 0x1C + 4n: priority in bits [6:2], level select in bit 1 (1 = level), and fast-output steering in bit 0. It reads back in the same layout. Control reads 0. Vector writes are ignored. Unmapped offsets, including configuration slots beyond the implemented lines, read 0 and ignore writes.
- R11: `bus_ready` is always high, and every accepted read gives `rd_valid` high with its data exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N | Active-high interrupt request inputs |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request ready, always high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench builds the controller with N = 8 lines. With that size, every non-empty subset of lines can be made pending and arbitrated under three priority assignments, one of which is all ties. It also makes it practical to send every non-zero value through the software-set register. With eight lines, the configuration slots past the last line also become reachable offsets, so the unmapped-slot behaviour is tested directly.

// File: rtl/pintc_pkg.sv
package pintc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 5;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VIRQ  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_VFIQ  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CFG0  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_SWSET = 8'h9C;

  localparam int NUM_OUTS = 2;
  typedef enum logic {SEL_NORMAL = 1'b0, SEL_FAST = 1'b1} out_sel_e;
endpackage

// File: rtl/pintc_capture.sv
module pintc_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] lvl,
  input  logic         pend_wr_en,
  input  logic [N-1:0] pend_wr_val,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q, pend_q;
  logic [N-1:0] rise, fall, set_v, clr_v;

  always_comb begin
    rise  = lines & ~prev_q;
    fall  = ~lines & prev_q;
    // level lines re-pend while high; edge lines only on a rising sample
    set_v = (lvl & lines) | (~lvl & rise) | sw_set;
    clr_v = ack_clr | (lvl & fall);
    if (pend_wr_en) clr_v = clr_v | (~pend_wr_val & ~(lvl & lines));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lines;
      pend_q <= (pend_q & ~clr_v) | set_v;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/pintc_arb.sv
module pintc_arb #(
  parameter int N  = 32,
  parameter int PW = 5,
  parameter int LW = 5
) (
  input  logic [N-1:0]         elig,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 any,
  output logic [LW-1:0]        win
);
  logic [PW-1:0] best;

  // ascending scan with <= so that ties fall to the higher line number
  always_comb begin
    any  = 1'b0;
    best = '0;
    win  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any || prio[i] <= best)) begin
        any  = 1'b1;
        best = prio[i];
        win  = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pintc_outstage.sv
module pintc_outstage #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm,
  input  logic          any,
  input  logic [LW-1:0] win,
  output logic          out,
  output logic [LW-1:0] vec
);
  logic          armed_q, out_q;
  logic [LW-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      vec_q   <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (armed_q && any) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      vec_q   <= win;
    end
  end

  assign out = out_q;
  assign vec = vec_q;
endmodule

// File: rtl/pintc.sv
module pintc
  import pintc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_lines,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int LW      = (N > 1) ? $clog2(N) : 1;
  localparam int CFG_END = int'(OFS_CFG0) + 4 * N;

  logic                 wr_en, rd_en, cfg_hit;
  logic [ADDR_W-1:0]    cfg_off;
  logic [LW-1:0]        cfg_idx;
  logic [N-1:0]         mask_q, lvl_q, fiq_q, pend_q;
  logic [N-1:0][PRIO_W-1:0] prio_q;
  logic [N-1:0]         sw_set, ack_clr;
  logic [NUM_OUTS-1:0]  rearm, outs, any_v;
  logic [NUM_OUTS-1:0][LW-1:0] vec, win_v;
  logic [NUM_OUTS-1:0][N-1:0]  elig;
  logic [DATA_W-1:0]    rd_mux, rd_data_q;
  logic                 rd_valid_q;
  logic                 unused_bits;

  assign bus_ready = 1'b1;
  assign wr_en     = bus_valid & bus_write;
  assign rd_en     = bus_valid & ~bus_write;

  always_comb begin
    cfg_off = bus_addr - OFS_CFG0;
    cfg_idx = cfg_off[LW+1:2];
    cfg_hit = (bus_addr >= OFS_CFG0) && (32'(bus_addr) < 32'(CFG_END))
              && (bus_addr[1:0] == 2'b00);
  end

  assign unused_bits = ^{cfg_off, bus_wdata};

  // configuration and mask registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      lvl_q  <= '0;
      fiq_q  <= '0;
      prio_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == OFS_MASK) mask_q <= bus_wdata[N-1:0];
      if (cfg_hit) begin
        prio_q[cfg_idx] <= bus_wdata[PRIO_W+1:2];
        lvl_q[cfg_idx]  <= bus_wdata[1];
        fiq_q[cfg_idx]  <= bus_wdata[0];
      end
    end
  end

  // software set: only the lowest set bit takes effect
  always_comb begin
    sw_set = '0;
    if (wr_en && bus_addr == OFS_SWSET) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (bus_wdata[i]) begin
          sw_set    = '0;
          sw_set[i] = 1'b1;
        end
      end
    end
  end

  // vector read acknowledges edge-type lines
  always_comb begin
    ack_clr = '0;
    if (rd_en && bus_addr == OFS_VIRQ) ack_clr[vec[SEL_NORMAL]] = 1'b1;
    if (rd_en && bus_addr == OFS_VFIQ) ack_clr[vec[SEL_FAST]]   = 1'b1;
    ack_clr = ack_clr & ~lvl_q;
  end

  pintc_capture #(.N(N)) cap_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines       (irq_lines),
    .lvl         (lvl_q),
    .pend_wr_en  (wr_en && bus_addr == OFS_PEND),
    .pend_wr_val (bus_wdata[N-1:0]),
    .sw_set      (sw_set),
    .ack_clr     (ack_clr),
    .pend        (pend_q)
  );

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    if (k == int'(SEL_FAST)) begin : g_fast
      assign elig[k] = pend_q & ~mask_q & fiq_q;
    end else begin : g_norm
      assign elig[k] = pend_q & ~mask_q & ~fiq_q;
    end

    assign rearm[k] = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[k];

    pintc_arb #(.N(N), .PW(PRIO_W), .LW(LW)) arb_i (
      .elig (elig[k]),
      .prio (prio_q),
      .any  (any_v[k]),
      .win  (win_v[k])
    );

    pintc_outstage #(.LW(LW)) ost_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rearm (rearm[k]),
      .any   (any_v[k]),
      .win   (win_v[k]),
      .out   (outs[k]),
      .vec   (vec[k])
    );
  end

  assign irq_o = outs[SEL_NORMAL];
  assign fiq_o = outs[SEL_FAST];

  // read mux, registered response
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_PEND: rd_mux = 32'(pend_q);
      OFS_MASK: rd_mux = 32'(mask_q);
      OFS_VIRQ: rd_mux = 32'(vec[SEL_NORMAL]);
      OFS_VFIQ: rd_mux = 32'(vec[SEL_FAST]);
      default: begin
        if (cfg_hit)
          rd_mux = 32'({prio_q[cfg_idx], lvl_q[cfg_idx], fiq_q[cfg_idx]});
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_en ? rd_mux : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/pintc_chk.sv
module pintc_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_o,
  input logic         fiq_o,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [N-1:0] steer,
  input logic [N-1:0] lvl,
  input logic [N-1:0] lines,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [7:0]   bus_addr,
  input logic [31:0]  bus_wdata,
  input logic         rd_valid
);
  logic rearm_norm, mask_wr;
  assign rearm_norm = bus_valid && bus_write && bus_addr == 8'h18 && bus_wdata[0];
  assign mask_wr    = bus_valid && bus_write && bus_addr == 8'h04;

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pend & ~mask & ~steer)));

  // R6
  fiq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(pend & ~mask & steer)));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm_norm) |=> irq_o);

  // R7
  irq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_norm |=> !irq_o);

  // R4
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl & lines)) |=> (($past(lvl & lines) & ~pend) == '0));

  // R2
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask == $past(bus_wdata[N-1:0])));

  // R11
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);
endmodule

bind pintc pintc_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .pend      (pend_q),
  .mask      (mask_q),
  .steer     (fiq_q),
  .lvl       (lvl_q),
  .lines     (irq_lines),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid)
);

// File: tb/pintc_tb_top.sv
module pintc_tb_top;
  localparam int N = 8;
  localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_VIRQ = 8'h10,
                         A_VFIQ = 8'h14, A_CTRL = 8'h18, A_CFG = 8'h1C,
                         A_SWSET = 8'h9C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_ready, rd_valid, irq_o, fiq_o;
  logic [31:0]  rd_data;
  int           total = 0, fails = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  pintc #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    chk(32'(bus_ready), 1, "R11 ready");
    @(negedge clk);
    bus_valid = 1'b0;
    chk(32'(rd_valid), 1, "R11 rd_valid");
    d = rd_data;
  endtask

  function automatic int prio_of(input int i, input int r);
    return (r == 2) ? 0 : ((i * 3 + r) % 4);
  endfunction

  function automatic int winner(input logic [N-1:0] pat, input int r);
    int best = -1;
    int bp = 0;
    for (int i = 0; i < N; i++)
      if (pat[i] && (best < 0 || prio_of(i, r) <= bp)) begin
        best = i; bp = prio_of(i, r);
      end
    return best;
  endfunction

  task automatic quiet();
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_PEND, 0);
    wr(A_CTRL, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(32'(irq_o), 0, "R1 irq_o");
    chk(32'(fiq_o), 0, "R1 fiq_o");
    rd(A_PEND, d); chk(d, 0, "R1 pend");
    rd(A_MASK, d); chk(d, 32'hFF, "R1 mask");
    for (int i = 0; i < N; i++) begin
      rd(A_CFG + 8'(4 * i), d); chk(d, 0, "R1 cfg");
    end
    rd(A_VIRQ, d); chk(d, 0, "R1 vec irq");
    rd(A_VFIQ, d); chk(d, 0, "R1 vec fiq");

    // R2 mask readback
    wr(A_MASK, 32'h5A); rd(A_MASK, d); chk(d, 32'h5A, "R2 mask readback");
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); chk(d, 32'hFF, "R2 mask width");

    // R6 R7 R8 arbitration sweep over every subset, three priority sets
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) wr(A_CFG + 8'(4 * i), 32'(prio_of(i, r)) << 2);
      for (int p = 1; p < (1 << N); p++) begin
        quiet();
        @(negedge clk); irq_lines = N'(p);
        @(negedge clk); irq_lines = '0;
        rd(A_PEND, d); chk(d, 32'(p), "R3 edge pend");
        chk(32'(irq_o), 0, "R2 masked no fire");
        wr(A_MASK, 0);
        repeat (2) @(negedge clk);
        chk(32'(irq_o), 1, "R7 fire");
        rd(A_VIRQ, d); chk(d, 32'(winner(N'(p), r)), "R6 winner");
        rd(A_PEND, d); chk(d, 32'(p) & ~(32'd1 << winner(N'(p), r)), "R8 edge ack");
      end
    end

    // R4 R5 R3 per-line level and edge behaviour
    quiet();
    for (int i = 0; i < N; i++) begin
      wr(A_CFG + 8'(4 * i), 2);
      @(negedge clk); irq_lines[i] = 1'b1;
      repeat (2) @(negedge clk);
      rd(A_PEND, d); chk(d, 32'd1 << i, "R4 level pend");
      wr(A_PEND, 0);
      rd(A_PEND, d); chk(d, 32'd1 << i, "R5 clear ignored");
      irq_lines[i] = 1'b0;
      repeat (2) @(negedge clk);
      rd(A_PEND, d); chk(d, 0, "R4 level drop");
      wr(A_CFG + 8'(4 * i), 0);
      @(negedge clk); irq_lines[i] = 1'b1;
      repeat (2) @(negedge clk);
      wr(A_PEND, 0);
      rd(A_PEND, d); chk(d, 0, "R3 held edge no repend");
      irq_lines[i] = 1'b0;
    end

    // R6 steering, R7 once-only and re-arm
    quiet();
    wr(A_CFG + 8'(4 * 5), 1);
    wr(A_CFG + 8'(4 * 2), 3 << 2);
    @(negedge clk); irq_lines = 8'h24;
    @(negedge clk); irq_lines = '0;
    wr(A_MASK, 0);
    repeat (2) @(negedge clk);
    chk(32'(irq_o), 1, "R6 irq raised");
    chk(32'(fiq_o), 1, "R6 fiq raised");
    rd(A_VFIQ, d); chk(d, 5, "R6 fiq vector");
    rd(A_VIRQ, d); chk(d, 2, "R6 irq vector");
    rd(A_PEND, d); chk(d, 0, "R8 both acked");
    @(negedge clk); irq_lines[6] = 1'b1;
    @(negedge clk); irq_lines[6] = 1'b0;
    repeat (2) @(negedge clk);
    chk(32'(irq_o), 1, "R7 still high");
    rd(A_VIRQ, d); chk(d, 2, "R7 vector held");
    wr(A_CTRL, 1);
    chk(32'(irq_o), 0, "R7 rearm lowers");
    chk(32'(fiq_o), 1, "R7 fiq untouched");
    @(negedge clk);
    chk(32'(irq_o), 1, "R7 refire");
    rd(A_VIRQ, d); chk(d, 6, "R7 new vector");

    // R8 level line is not acknowledged by the vector read
    quiet();
    wr(A_CFG + 8'(4 * 3), 2);
    @(negedge clk); irq_lines[3] = 1'b1;
    wr(A_MASK, 0);
    repeat (2) @(negedge clk);
    rd(A_VIRQ, d); chk(d, 3, "R8 level vector");
    rd(A_PEND, d); chk(d, 32'h08, "R8 level kept");
    irq_lines[3] = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_PEND, d); chk(d, 0, "R4 level drop after ack");
    wr(A_CFG + 8'(4 * 3), 0);

    // R9 software set sweep
    wr(A_MASK, 32'hFFFF_FFFF);
    for (int v = 1; v < (1 << N); v++) begin
      wr(A_PEND, 0);
      wr(A_SWSET, 32'(v));
      rd(A_PEND, d); chk(d, 32'(v & -v), "R9 lowest bit");
    end
    rd(A_SWSET, d); chk(d, 0, "R9 reads zero");

    // R10 layout, zero-read and ignored registers
    wr(A_CFG + 8'(4 * 4), 32'hFFFF_FFFF);
    rd(A_CFG + 8'(4 * 4), d); chk(d, 32'h7F, "R10 cfg layout");
    wr(A_CFG + 8'(4 * 4), 32'h29);
    rd(A_CFG + 8'(4 * 4), d); chk(d, 32'h29, "R10 cfg value");
    rd(A_CTRL, d); chk(d, 0, "R10 ctrl zero");
    wr(A_VIRQ, 32'h5);
    rd(A_VIRQ, d); chk(d, 3, "R10 vector read-only");
    wr(A_PEND, 0); wr(A_SWSET, 32'h2);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(A_CFG + 8'(4 * N), 32'hFFFF_FFFF);
    rd(8'h0C, d); chk(d, 0, "R10 unmapped zero");
    rd(A_CFG + 8'(4 * N), d); chk(d, 0, "R10 slot past lines");
    rd(A_PEND, d); chk(d, 2, "R10 pend untouched");
    rd(A_MASK, d); chk(d, 32'hFF, "R10 mask untouched");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule